// File: doc/BRIEF.md
# Port-Write Message Capture Unit

This unit takes inbound port-write maintenance messages from a word stream and stores one message at a time into memory at a base address chosen by software. Each message is a fixed frame of sixteen 32-bit words. The first word of a frame decides its fate. If the unit is enabled and its one-entry queue is empty and idle, the frame is captured and written word by word, in ascending order, through a memory-write port. If the queue is full or a capture is still in flight, the frame is dropped and a discard flag is raised. If the unit is disabled, the frame is ignored.

Software works the unit through three registers on a simple register bus: mode, status and buffer base. A completed capture latches a queue-full state and a queue-full interrupt flag. A separate error input latches a transaction-error flag. One interrupt output combines the masked flags. A clear-queue command frees the single entry for the next message. The transaction error can be cleared only while the unit is disabled, and the base address and the snoop setting are frozen while the unit is enabled.

Top module: `pwCapture`

## Requirements
- R1: After reset the mode, status and base registers read 0, the interrupt output is 0 and no memory write is issued.
- R2: A captured frame produces sixteen memory writes to base+4*i for word i = 0..15, each carrying word i and appearing in the cycle after that word is taken.
- R3: In the cycle after the last memory write of a frame, status bit 20 (queue full) and status bit 4 (queue-full interrupt) read 1.
- R4: A frame whose first word arrives while the queue is full or busy produces no memory write and sets status bit 3 (discarded).
- R5: Writing the mode register with bit 1 set clears the queue-full state; bit 1 always reads back 0, and the next frame is captured again.
- R6: Status bits 4 and 3 clear when the status register is written with a 1 in that position; writing 0 leaves them unchanged.
- R7: A pulse on msgErr sets status bit 7; a write of 1 to that bit clears it only while mode bit 0 (enable) is 0.
- R8: Writes to the base register and to mode bit 20 (snoop) are ignored while mode bit 0 is 1; mode bits 8 and 5 and the enable stay writable.
- R9: irq is 1 exactly when (status bit 4 and mode bit 8) or (status bit 7 and mode bit 5) is true.
- R10: Status bit 2 (busy) reads 1 from the cycle after the first word is taken until the queue-full state is set.
- R11: While mode bit 0 is 0, incoming frames cause no memory writes and change no status bit.
- R12: When a flag is set and cleared by software in the same cycle, it reads 1 afterwards.
- Register select codes: 0 = mode, 1 = status, 2 = base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regSel | input | 2 | Register select (0 mode, 1 status, 2 base) |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Read data of the selected register |
| msgValid | input | 1 | A message word is present this cycle |
| msgData | input | 32 | Message word |
| msgErr | input | 1 | Transaction error pulse from the link |
| memWrEn | output | 1 | Memory write strobe |
| memAddr | output | 32 | Memory write byte address |
| memWrData | output | 32 | Memory write data |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can meet in the same cycle: the hardware setting a status flag and software clearing it with a write of one. The bench lines up a status write with the clock edge on which the last word of a frame lands in memory, so the queue-full interrupt is set and cleared at once, and it places a discard-flag clear on the very cycle of the first word of a frame that is being dropped. In both cases the flag must read 1 afterwards, while a clear in any other cycle must take it to 0.

// File: rtl/pwcPkg.sv
package pwcPkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;

  // mode register bit positions
  localparam int M_EN    = 0;
  localparam int M_CQ    = 1;
  localparam int M_EIE   = 5;
  localparam int M_QFIE  = 8;
  localparam int M_SNOOP = 20;

  // status register bit positions
  localparam int S_BUSY  = 2;
  localparam int S_DISC  = 3;
  localparam int S_QFI   = 4;
  localparam int S_TE    = 7;
  localparam int S_FULL  = 20;

  // register select codes
  localparam logic [1:0] SEL_MODE = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_BASE = 2'd2;

  typedef struct packed {
    logic              startCapture;
    logic [ADDR_W-1:0] baseAddr;
  } dpStrobe_t;
endpackage

// File: rtl/pwcDatapath.sv
module pwcDatapath
  import pwcPkg::*;
#(
  parameter int WORDS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              msgValid,
  input  logic [DATA_W-1:0] msgData,
  input  dpStrobe_t         strobes,
  output logic              frameHead,
  output logic              busy,
  output logic              doneStrobe,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData
);
  localparam int CNT_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORDS - 1);

  logic [CNT_W-1:0]  wordCnt;
  logic              capturing;
  logic [ADDR_W-1:0] heldBase;
  logic              lastFlag;
  logic              takeWord;
  logic [ADDR_W-1:0] curBase;
  logic [ADDR_W-1:0] wordOffset;

  assign frameHead  = (wordCnt == '0);
  assign takeWord   = msgValid && (strobes.startCapture || capturing);
  assign curBase    = strobes.startCapture ? strobes.baseAddr : heldBase;
  assign wordOffset = ADDR_W'(wordCnt) << 2;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordCnt   <= '0;
      capturing <= 1'b0;
      heldBase  <= '0;
    end else begin
      if (msgValid) begin
        wordCnt <= (wordCnt == LAST_IDX) ? '0 : wordCnt + 1'b1;
      end
      if (strobes.startCapture) begin
        heldBase <= strobes.baseAddr;
      end
      if (takeWord && wordCnt == LAST_IDX) begin
        capturing <= 1'b0;
      end else if (strobes.startCapture) begin
        capturing <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memWrEn   <= 1'b0;
      memAddr   <= '0;
      memWrData <= '0;
      lastFlag  <= 1'b0;
    end else begin
      memWrEn  <= takeWord;
      lastFlag <= takeWord && (wordCnt == LAST_IDX);
      if (takeWord) begin
        memAddr   <= curBase + wordOffset;
        memWrData <= msgData;
      end
    end
  end

  assign doneStrobe = memWrEn && lastFlag;
  assign busy       = capturing || memWrEn;
endmodule

// File: rtl/pwcControl.sv
module pwcControl
  import pwcPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [1:0]        regSel,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              msgValid,
  input  logic              msgErr,
  input  logic              frameHead,
  input  logic              dpBusy,
  input  logic              doneStrobe,
  output dpStrobe_t         strobes,
  output logic              irq,
  output logic [DATA_W-1:0] modeView,
  output logic [DATA_W-1:0] statusView,
  output logic [ADDR_W-1:0] baseView
);
  logic              modeEn, modeSnoop, modeQfie, modeEie;
  logic [ADDR_W-1:0] baseReg;
  logic              qFull, teFlag, qfiFlag, discFlag;
  logic              wrMode, wrStat, wrBase;
  logic              headSeen, dropHead;

  assign wrMode   = regWr && (regSel == SEL_MODE);
  assign wrStat   = regWr && (regSel == SEL_STAT);
  assign wrBase   = regWr && (regSel == SEL_BASE);
  assign headSeen = msgValid && frameHead && modeEn;
  assign dropHead = headSeen && (qFull || dpBusy);

  assign strobes.startCapture = headSeen && !qFull && !dpBusy;
  assign strobes.baseAddr     = baseReg;

  // configuration
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeEn    <= 1'b0;
      modeSnoop <= 1'b0;
      modeQfie  <= 1'b0;
      modeEie   <= 1'b0;
      baseReg   <= '0;
    end else begin
      if (wrMode) begin
        modeEn   <= regWdata[M_EN];
        modeQfie <= regWdata[M_QFIE];
        modeEie  <= regWdata[M_EIE];
        if (!modeEn) begin
          modeSnoop <= regWdata[M_SNOOP];
        end
      end
      if (wrBase && !modeEn) begin
        baseReg <= regWdata;
      end
    end
  end

  // status flags: a hardware set wins over a software clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      qFull    <= 1'b0;
      qfiFlag  <= 1'b0;
      discFlag <= 1'b0;
      teFlag   <= 1'b0;
    end else begin
      if (doneStrobe) begin
        qFull <= 1'b1;
      end else if (wrMode && regWdata[M_CQ]) begin
        qFull <= 1'b0;
      end

      if (doneStrobe) begin
        qfiFlag <= 1'b1;
      end else if (wrStat && regWdata[S_QFI]) begin
        qfiFlag <= 1'b0;
      end

      if (dropHead) begin
        discFlag <= 1'b1;
      end else if (wrStat && regWdata[S_DISC]) begin
        discFlag <= 1'b0;
      end

      if (msgErr) begin
        teFlag <= 1'b1;
      end else if (wrStat && regWdata[S_TE] && !modeEn) begin
        teFlag <= 1'b0;
      end
    end
  end

  always_comb begin
    modeView          = '0;
    modeView[M_EN]    = modeEn;
    modeView[M_EIE]   = modeEie;
    modeView[M_QFIE]  = modeQfie;
    modeView[M_SNOOP] = modeSnoop;

    statusView         = '0;
    statusView[S_BUSY] = dpBusy;
    statusView[S_DISC] = discFlag;
    statusView[S_QFI]  = qfiFlag;
    statusView[S_TE]   = teFlag;
    statusView[S_FULL] = qFull;

    baseView = baseReg;

    case (regSel)
      SEL_MODE: regRdata = modeView;
      SEL_STAT: regRdata = statusView;
      SEL_BASE: regRdata = baseReg;
      default:  regRdata = '0;
    endcase
  end

  assign irq = (qfiFlag && modeQfie) || (teFlag && modeEie);
endmodule

// File: rtl/pwCapture.sv
module pwCapture
  import pwcPkg::*;
#(
  parameter int WORDS = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic [1:0]  regSel,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  input  logic        msgValid,
  input  logic [31:0] msgData,
  input  logic        msgErr,
  output logic        memWrEn,
  output logic [31:0] memAddr,
  output logic [31:0] memWrData,
  output logic        irq
);
  dpStrobe_t         strobes;
  logic              frameHead;
  logic              dpBusy;
  logic              doneStrobe;
  logic [DATA_W-1:0] modeView;
  logic [DATA_W-1:0] statusView;
  logic [ADDR_W-1:0] baseView;

  pwcControl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .regWr      (regWr),
    .regSel     (regSel),
    .regWdata   (regWdata),
    .regRdata   (regRdata),
    .msgValid   (msgValid),
    .msgErr     (msgErr),
    .frameHead  (frameHead),
    .dpBusy     (dpBusy),
    .doneStrobe (doneStrobe),
    .strobes    (strobes),
    .irq        (irq),
    .modeView   (modeView),
    .statusView (statusView),
    .baseView   (baseView)
  );

  pwcDatapath #(.WORDS(WORDS)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .msgValid   (msgValid),
    .msgData    (msgData),
    .strobes    (strobes),
    .frameHead  (frameHead),
    .busy       (dpBusy),
    .doneStrobe (doneStrobe),
    .memWrEn    (memWrEn),
    .memAddr    (memAddr),
    .memWrData  (memWrData)
  );
endmodule

// File: rtl/pwCaptureChk.sv
module pwCaptureChk (
  input logic        clk,
  input logic        rstN,
  input logic        memWrEn,
  input logic [31:0] memAddr,
  input logic        regWr,
  input logic [1:0]  regSel,
  input logic [31:0] regWdata,
  input logic [31:0] modeView,
  input logic [31:0] statusView,
  input logic [31:0] baseView
);
  // R3
  full_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusView[20]) |-> $past(memWrEn));

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && $past(memWrEn)) |-> (memAddr == $past(memAddr) + 32'd4));

  // R6
  qfi_clear_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusView[4]) |-> $past(regWr && regSel == 2'd1 && regWdata[4]));

  // R7
  te_clear_disabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusView[7]) |-> $past(!modeView[0]));

  // R8
  base_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(modeView[0]) |-> $stable(baseView));
endmodule

bind pwCapture pwCaptureChk uChk (
  .clk        (clk),
  .rstN       (rstN),
  .memWrEn    (memWrEn),
  .memAddr    (memAddr),
  .regWr      (regWr),
  .regSel     (regSel),
  .regWdata   (regWdata),
  .modeView   (modeView),
  .statusView (statusView),
  .baseView   (baseView)
);

// File: tb/tb_pwCapture.sv
module tb_pwCapture;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        msgValid = 1'b0;
  logic [31:0] msgData = '0;
  logic        msgErr = 1'b0;
  logic        memWrEn;
  logic [31:0] memAddr;
  logic [31:0] memWrData;
  logic        irq;

  int testCnt = 0;
  int failCnt = 0;
  bit finished = 0;

  logic [63:0] expQ[$];

  localparam logic [31:0] M_BASE_CFG = 32'h0010_0121; // snoop|qfie|eie|en

  always #5 clk = ~clk;

  pwCapture dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regSel(regSel),
    .regWdata(regWdata), .regRdata(regRdata), .msgValid(msgValid),
    .msgData(msgData), .msgErr(msgErr), .memWrEn(memWrEn),
    .memAddr(memAddr), .memWrData(memWrData), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each memory write
  always @(negedge clk) begin
    if (rstN && memWrEn) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R4/R11 unexpected memory write", memAddr, 32'h0);
      end else begin
        logic [63:0] e;
        e = expQ.pop_front();
        check(memAddr == e[63:32], "R2 write address", memAddr, e[63:32]);
        check(memWrData == e[31:0], "R2 write data", memWrData, e[31:0]);
      end
    end
  end

  task automatic writeReg(input logic [1:0] sel, input logic [31:0] val);
    @(negedge clk);
    regWr = 1'b1; regSel = sel; regWdata = val;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] sel, output logic [31:0] val);
    regSel = sel;
    #1;
    val = regRdata;
  endtask

  // driver: one 16-word frame; optional status write at word index sideAt (16 = completion edge)
  task automatic sendMsg(input int seed, input logic [31:0] base, input bit accept,
                         input int sideAt, input logic [31:0] sideVal);
    logic [31:0] rd;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      msgValid = 1'b1;
      msgData  = 32'hA000_0000 | (seed << 8) | i;
      regWr    = (i == sideAt);
      regSel   = 2'd1;
      regWdata = sideVal;
      if (accept) expQ.push_back({base + 32'(4 * i), msgData});
      if (accept && sideAt < 0 && i == 8) begin
        readReg(2'd1, rd);
        check(rd[2] == 1'b1, "R10 busy during capture", {31'b0, rd[2]}, 32'h1);
      end
    end
    @(negedge clk);
    msgValid = 1'b0;
    regWr    = (sideAt == 16);
    regSel   = 2'd1;
    regWdata = sideVal;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failCnt++;
      testCnt++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    readReg(2'd0, rd); check(rd == 0, "R1 mode after reset", rd, 0);
    readReg(2'd1, rd); check(rd == 0, "R1 status after reset", rd, 0);
    readReg(2'd2, rd); check(rd == 0, "R1 base after reset", rd, 0);
    check(irq == 0 && memWrEn == 0, "R1 outputs after reset", {30'b0, irq, memWrEn}, 0);

    writeReg(2'd2, 32'h0000_1000);
    writeReg(2'd0, M_BASE_CFG);
    readReg(2'd0, rd); check(rd == M_BASE_CFG, "R8 mode writable while disabled", rd, M_BASE_CFG);

    // R2 R3 R10 R9
    sendMsg(1, 32'h1000, 1, -1, 0);
    readReg(2'd1, rd); check(rd == 32'h0010_0010, "R3 full and qfi after capture", rd, 32'h0010_0010);
    check(irq == 1, "R9 irq from qfi", {31'b0, irq}, 1);

    // R4
    sendMsg(2, 32'h1000, 0, -1, 0);
    readReg(2'd1, rd); check(rd == 32'h0010_0018, "R4 discard when full", rd, 32'h0010_0018);

    // R6
    writeReg(2'd1, 32'h0);
    readReg(2'd1, rd); check(rd == 32'h0010_0018, "R6 write zero no effect", rd, 32'h0010_0018);
    writeReg(2'd1, 32'h8);
    readReg(2'd1, rd); check(rd == 32'h0010_0010, "R6 w1c discard", rd, 32'h0010_0010);
    writeReg(2'd1, 32'h10);
    readReg(2'd1, rd); check(rd == 32'h0010_0000, "R6 w1c qfi", rd, 32'h0010_0000);
    check(irq == 0, "R9 irq low after qfi clear", {31'b0, irq}, 0);

    // R5
    writeReg(2'd0, M_BASE_CFG | 32'h2);
    readReg(2'd0, rd); check(rd == M_BASE_CFG, "R5 clear-queue bit reads 0", rd, M_BASE_CFG);
    readReg(2'd1, rd); check(rd == 32'h0, "R5 queue emptied", rd, 0);

    // R8 frozen config while enabled
    writeReg(2'd2, 32'h0000_2000);
    readReg(2'd2, rd); check(rd == 32'h1000, "R8 base frozen while enabled", rd, 32'h1000);
    writeReg(2'd0, 32'h0000_0121);
    readReg(2'd0, rd); check(rd == M_BASE_CFG, "R8 snoop frozen while enabled", rd, M_BASE_CFG);
    writeReg(2'd0, M_BASE_CFG);

    // R12 qfi set and cleared at the completion edge; R5 next frame captured
    sendMsg(3, 32'h1000, 1, 16, 32'h10);
    readReg(2'd1, rd); check(rd == 32'h0010_0010, "R12 qfi set wins over clear", rd, 32'h0010_0010);
    // R12 discard set and cleared on the head word
    sendMsg(4, 32'h1000, 0, 0, 32'h8);
    readReg(2'd1, rd); check(rd == 32'h0010_0018, "R12 discard set wins over clear", rd, 32'h0010_0018);
    writeReg(2'd1, 32'h18);
    writeReg(2'd0, M_BASE_CFG | 32'h2);
    readReg(2'd1, rd); check(rd == 32'h0, "R6 flags cleared", rd, 0);

    // R7 transaction error
    @(negedge clk); msgErr = 1'b1;
    @(negedge clk); msgErr = 1'b0;
    readReg(2'd1, rd); check(rd == 32'h80, "R7 error latched", rd, 32'h80);
    check(irq == 1, "R9 irq from error", {31'b0, irq}, 1);
    writeReg(2'd1, 32'h80);
    readReg(2'd1, rd); check(rd == 32'h80, "R7 error kept while enabled", rd, 32'h80);
    writeReg(2'd0, 32'h0010_0120);
    writeReg(2'd1, 32'h80);
    readReg(2'd1, rd); check(rd == 32'h0, "R7 error cleared while disabled", rd, 0);
    check(irq == 0, "R9 irq low after error clear", {31'b0, irq}, 0);

    // R11 disabled unit ignores frames
    sendMsg(5, 32'h1000, 0, -1, 0);
    readReg(2'd1, rd); check(rd == 32'h0, "R11 status unchanged while disabled", rd, 0);
    writeReg(2'd2, 32'h0000_3000);
    readReg(2'd2, rd); check(rd == 32'h3000, "R8 base writable while disabled", rd, 32'h3000);
    writeReg(2'd0, M_BASE_CFG);
    sendMsg(6, 32'h3000, 1, -1, 0);
    readReg(2'd1, rd); check(rd == 32'h0010_0010, "R2 capture at new base", rd, 32'h0010_0010);

    repeat (2) @(negedge clk);
    check(expQ.size() == 0, "R2 all expected writes seen", expQ.size(), 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule